// File: doc/BRIEF.md
# Ternary Content-Addressable Search Array

The block is a small ternary lookup table. Each physical row stores a data word and a per-row mask word. A bit whose mask is 1 must equal the matching search-key bit. A bit whose mask is 0 accepts either value. A search presents a key to every row in parallel. One of eight global mask registers is applied at the same time and can exclude chosen bit positions from every row. The search reports whether anything matched and, if so, the lowest-numbered matching entry.

Rows can be grouped so that one logical entry spans one, two or four adjacent physical rows. With the default 64 rows of 68 bits, the three shapes are 64×68, 32×136 and 16×272. A wide key carries one 68-bit slice per row of the group. A grouped entry matches only when every row in it matches. The reported index is the logical entry number.

Rows and global masks are loaded through dedicated write ports. A read port returns a row's stored data and mask.

Top module: `tcam_search`

## Requirements
- R1: While reset is asserted, the block clears every stored data word to 0 and sets every stored mask word to all ones. It clears all global masks to 0 and drives `res_vld`, `res_hit`, `res_idx`, `rd_data` and `rd_mask` to 0. As a result, after reset only an all-zero key slice hits, and it hits row 0.
- R2: `res_vld` is 1 in exactly the cycle that follows a cycle with `srch_en` high. `res_hit` and `res_idx` change only on such a cycle and otherwise hold their values.
- R3: A stored mask bit of 1 makes the corresponding data bit take part in the comparison. A stored mask bit of 0 makes that bit position don't-care for that row.
- R4: `srch_gm_sel` picks one of the global masks, which are loaded through `gm_wr_*`. A 1 in the chosen global mask makes that bit position don't-care for every row during that search.
- R5: When several logical entries match, `res_idx` is the lowest matching index.
- R6: A search with no matching entry gives `res_hit`=0 and `res_idx`=0.
- R7: `cfg_shape` selects the grouping: 0 means one row per entry, 1 means two rows per entry and 2 means four rows per entry; 3 behaves like 0. Slice k of the key (bits 68k+67:68k) is compared with row k of the group. In the one-row shape, only slice 0 is used. A grouped entry matches only if all of its rows match, and the index reported is the entry number.
- R8: A write stores data and mask into row `wr_row`. A search issued in the same cycle as a write still sees the old contents, and a later search sees the new contents. `rd_en` returns the stored data and mask on `rd_data`/`rd_mask` one cycle later.
- R9: A reported hit index is always below the number of logical entries of the active shape.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_shape | input | 2 | Entry grouping: 0 one row, 1 two rows, 2 four rows |
| wr_en | input | 1 | Row write strobe |
| wr_row | input | 6 | Physical row to write |
| wr_data | input | 68 | Data word to store |
| wr_mask | input | 68 | Per-row mask to store (1 = compare) |
| gm_wr_en | input | 1 | Global mask write strobe |
| gm_wr_sel | input | 3 | Global mask register to write |
| gm_wr_data | input | 68 | Global mask value (1 = ignore bit) |
| rd_en | input | 1 | Row read strobe |
| rd_row | input | 6 | Physical row to read |
| rd_data | output | 68 | Data word read back |
| rd_mask | output | 68 | Mask word read back |
| srch_en | input | 1 | Search strobe |
| srch_key | input | 272 | Search key, one 68-bit slice per grouped row |
| srch_gm_sel | input | 3 | Global mask applied to this search |
| res_vld | output | 1 | Result valid pulse |
| res_hit | output | 1 | Some entry matched |
| res_idx | output | 6 | Lowest matching logical entry |

## Verification
The assertions check the following on every cycle:
- the result pulse follows a search by exactly one cycle, and the hit and index hold between searches;
- a miss carries index 0;
- the reported winner is set in the captured entry-match vector, and no lower entry is set;
- the index stays inside the active shape's range;
- in the four-row shape, all four rows of the winner matched.

Only the bench scenarios show the other behaviours:
- the ternary comparison itself, including stored don't-care bits and a selected global mask overriding a stored mask;
- the slice-to-row pairing in the wide shapes;
- the reset contents of the array;
- a write in the same cycle as a search staying invisible to that search.

// File: rtl/tcam_pkg.sv
package tcam_pkg;

  typedef enum logic [1:0] {
    SHAPE_X1   = 2'd0,
    SHAPE_X2   = 2'd1,
    SHAPE_X4   = 2'd2,
    SHAPE_RSVD = 2'd3
  } shape_e;

  // Which key slice a physical row compares against, given the low row bits.
  function automatic logic [1:0] slice_sel(input shape_e shape, input logic [1:0] row_lsb);
    case (shape)
      SHAPE_X2: slice_sel = {1'b0, row_lsb[0]};
      SHAPE_X4: slice_sel = row_lsb;
      default:  slice_sel = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/tcam_store.sv
module tcam_store #(
  parameter int ROW_W = 68,
  parameter int ROWS  = 64,
  parameter int NGM   = 8,
  localparam int AW   = $clog2(ROWS),
  localparam int GW   = $clog2(NGM)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [AW-1:0]                  wr_row,
  input  logic [ROW_W-1:0]               wr_data,
  input  logic [ROW_W-1:0]               wr_mask,
  input  logic                           gm_wr_en,
  input  logic [GW-1:0]                  gm_wr_sel,
  input  logic [ROW_W-1:0]               gm_wr_data,
  input  logic [GW-1:0]                  gm_rd_sel,
  input  logic                           rd_en,
  input  logic [AW-1:0]                  rd_row,
  output logic [ROW_W-1:0]               rd_data,
  output logic [ROW_W-1:0]               rd_mask,
  output logic [ROWS-1:0][ROW_W-1:0]     data_o,
  output logic [ROWS-1:0][ROW_W-1:0]     mask_o,
  output logic [ROW_W-1:0]               gmask_o
);

  logic [ROW_W-1:0] data_q [ROWS];
  logic [ROW_W-1:0] mask_q [ROWS];
  logic [ROW_W-1:0] gm_q   [NGM];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ROWS; i++) begin
        data_q[i] <= '0;
        mask_q[i] <= '1;
      end
    end else if (wr_en) begin
      data_q[wr_row] <= wr_data;
      mask_q[wr_row] <= wr_mask;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NGM; i++) gm_q[i] <= '0;
    end else if (gm_wr_en) begin
      gm_q[gm_wr_sel] <= gm_wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data <= '0;
      rd_mask <= '0;
    end else if (rd_en) begin
      rd_data <= data_q[rd_row];
      rd_mask <= mask_q[rd_row];
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_flat
    assign data_o[r] = data_q[r];
    assign mask_o[r] = mask_q[r];
  end

  assign gmask_o = gm_q[gm_rd_sel];

endmodule

// File: rtl/tcam_match.sv
module tcam_match
  import tcam_pkg::*;
#(
  parameter int ROW_W = 68,
  parameter int ROWS  = 64,
  localparam int KEY_W = 4 * ROW_W
) (
  input  shape_e                         shape,
  input  logic [KEY_W-1:0]               key,
  input  logic [ROW_W-1:0]               gmask,
  input  logic [ROWS-1:0][ROW_W-1:0]     data,
  input  logic [ROWS-1:0][ROW_W-1:0]     mask,
  output logic [ROWS-1:0]                row_hit,
  output logic [ROWS-1:0]                ent_hit
);

  // A bit disagrees only if it differs, is compared by the row and is not globally ignored.
  function automatic logic cell_match(input logic [ROW_W-1:0] d, input logic [ROW_W-1:0] m,
                                      input logic [ROW_W-1:0] g, input logic [ROW_W-1:0] k);
    cell_match = ~|((d ^ k) & m & ~g);
  endfunction

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    localparam logic [1:0] RL = 2'(r % 4);
    logic [1:0] sl;
    assign sl         = slice_sel(shape, RL);
    assign row_hit[r] = cell_match(data[r], mask[r], gmask, key[sl*ROW_W +: ROW_W]);
  end

  for (genvar e = 0; e < ROWS; e++) begin : g_ent
    logic pair_ok;
    logic quad_ok;
    if (2 * e + 1 < ROWS) begin : g_p
      assign pair_ok = &row_hit[2*e +: 2];
    end else begin : g_np
      assign pair_ok = 1'b0;
    end
    if (4 * e + 3 < ROWS) begin : g_q
      assign quad_ok = &row_hit[4*e +: 4];
    end else begin : g_nq
      assign quad_ok = 1'b0;
    end
    assign ent_hit[e] = (shape == SHAPE_X2) ? pair_ok :
                        (shape == SHAPE_X4) ? quad_ok : row_hit[e];
  end

endmodule

// File: rtl/tcam_prio.sv
module tcam_prio #(
  parameter int N  = 64,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);

  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end

endmodule

// File: rtl/tcam_search.sv
module tcam_search
  import tcam_pkg::*;
#(
  parameter int ROW_W = 68,
  parameter int ROWS  = 64,
  parameter int NGM   = 8,
  localparam int AW    = $clog2(ROWS),
  localparam int GW    = $clog2(NGM),
  localparam int KEY_W = 4 * ROW_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_shape,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_row,
  input  logic [ROW_W-1:0] wr_data,
  input  logic [ROW_W-1:0] wr_mask,
  input  logic             gm_wr_en,
  input  logic [GW-1:0]    gm_wr_sel,
  input  logic [ROW_W-1:0] gm_wr_data,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_row,
  output logic [ROW_W-1:0] rd_data,
  output logic [ROW_W-1:0] rd_mask,
  input  logic             srch_en,
  input  logic [KEY_W-1:0] srch_key,
  input  logic [GW-1:0]    srch_gm_sel,
  output logic             res_vld,
  output logic             res_hit,
  output logic [AW-1:0]    res_idx
);

  shape_e                     shape;
  logic [ROWS-1:0][ROW_W-1:0] arr_data;
  logic [ROWS-1:0][ROW_W-1:0] arr_mask;
  logic [ROW_W-1:0]           sel_gmask;
  logic [ROWS-1:0]            row_hit;
  logic [ROWS-1:0]            ent_hit;
  logic                       pe_any;
  logic [AW-1:0]              pe_idx;

  assign shape = shape_e'(cfg_shape);

  tcam_store #(.ROW_W(ROW_W), .ROWS(ROWS), .NGM(NGM)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_row     (wr_row),
    .wr_data    (wr_data),
    .wr_mask    (wr_mask),
    .gm_wr_en   (gm_wr_en),
    .gm_wr_sel  (gm_wr_sel),
    .gm_wr_data (gm_wr_data),
    .gm_rd_sel  (srch_gm_sel),
    .rd_en      (rd_en),
    .rd_row     (rd_row),
    .rd_data    (rd_data),
    .rd_mask    (rd_mask),
    .data_o     (arr_data),
    .mask_o     (arr_mask),
    .gmask_o    (sel_gmask)
  );

  tcam_match #(.ROW_W(ROW_W), .ROWS(ROWS)) u_match (
    .shape   (shape),
    .key     (srch_key),
    .gmask   (sel_gmask),
    .data    (arr_data),
    .mask    (arr_mask),
    .row_hit (row_hit),
    .ent_hit (ent_hit)
  );

  tcam_prio #(.N(ROWS), .IW(AW)) u_prio (
    .req (ent_hit),
    .any (pe_any),
    .idx (pe_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_vld <= 1'b0;
      res_hit <= 1'b0;
      res_idx <= '0;
    end else begin
      res_vld <= srch_en;
      if (srch_en) begin
        res_hit <= pe_any;
        res_idx <= pe_any ? pe_idx : '0;
      end
    end
  end

endmodule

// File: rtl/tcam_search_chk.sv
module tcam_search_chk #(
  parameter int ROWS = 64,
  parameter int AW   = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      cfg_shape,
  input logic            srch_en,
  input logic [ROWS-1:0] row_hit,
  input logic [ROWS-1:0] ent_hit,
  input logic            res_vld,
  input logic            res_hit,
  input logic [AW-1:0]   res_idx
);

  logic [ROWS-1:0] ent_q;
  logic [ROWS-1:0] row_q;
  logic [1:0]      shape_q;
  logic [ROWS-1:0] below;
  logic [ROWS-1:0] quad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_q   <= '0;
      row_q   <= '0;
      shape_q <= '0;
    end else if (srch_en) begin
      ent_q   <= ent_hit;
      row_q   <= row_hit;
      shape_q <= cfg_shape;
    end
  end

  assign below = (ROWS'(1) << res_idx) - ROWS'(1);
  assign quad  = (row_q >> {res_idx, 2'b00}) & ROWS'(15);

  p_vld_after_search_r2: assert property (@(posedge clk) disable iff (!rst_n)
    srch_en |=> res_vld);
  p_no_vld_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !srch_en |=> !res_vld);
  p_result_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !srch_en |=> ($stable(res_hit) && $stable(res_idx)));
  p_miss_zero_idx_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && !res_hit) |-> (res_idx == '0));
  p_hit_any_r5: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |-> (res_hit == (|ent_q)));
  p_winner_matched_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && res_hit) |-> ent_q[res_idx]);
  p_none_lower_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && res_hit) |-> ((ent_q & below) == '0));
  p_range_x2_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && res_hit && shape_q == 2'd1) |-> (int'(res_idx) < ROWS / 2));
  p_range_x4_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && res_hit && shape_q == 2'd2) |-> (int'(res_idx) < ROWS / 4));
  p_quad_all_rows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && res_hit && shape_q == 2'd2) |-> (quad == ROWS'(15)));

endmodule

bind tcam_search tcam_search_chk #(.ROWS(ROWS), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_shape (cfg_shape),
  .srch_en   (srch_en),
  .row_hit   (row_hit),
  .ent_hit   (ent_hit),
  .res_vld   (res_vld),
  .res_hit   (res_hit),
  .res_idx   (res_idx)
);

// File: tb/sim_tcam_search.sv
module sim_tcam_search;

  localparam int W = 68;

  typedef struct packed {
    logic [1:0]   mode;
    logic [2:0]   gsel;
    logic [W-1:0] k3;
    logic [W-1:0] k2;
    logic [W-1:0] k1;
    logic [W-1:0] k0;
    logic         hit;
    logic [5:0]   idx;
  } vec_t;

  localparam logic [W-1:0] Z  = '0;
  localparam logic [W-1:0] HB = {1'b1, 67'd1};
  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 3'd0, Z, Z, Z, 68'd7,    1'b1, 6'd7},
    '{2'd0, 3'd0, Z, Z, Z, 68'd12,   1'b1, 6'd10},
    '{2'd0, 3'd0, Z, Z, Z, 68'd3,    1'b1, 6'd3},
    '{2'd0, 3'd0, Z, Z, Z, 68'd64,   1'b0, 6'd0},
    '{2'd0, 3'd3, Z, Z, Z, 68'h35,   1'b1, 6'd5},
    '{2'd0, 3'd0, Z, Z, Z, 68'h35,   1'b1, 6'd53},
    '{2'd0, 3'd7, Z, Z, Z, HB,       1'b1, 6'd1},
    '{2'd0, 3'd0, Z, Z, Z, HB,       1'b0, 6'd0},
    '{2'd0, 3'd0, Z, Z, 68'h3C, 68'd63, 1'b1, 6'd63},
    '{2'd1, 3'd0, Z, Z, 68'd9,  68'd8,  1'b1, 6'd4},
    '{2'd1, 3'd0, Z, Z, 68'd11, 68'd12, 1'b1, 6'd5},
    '{2'd1, 3'd0, Z, Z, 68'd13, 68'd12, 1'b1, 6'd6},
    '{2'd1, 3'd0, Z, Z, 68'd8,  68'd9,  1'b0, 6'd0},
    '{2'd1, 3'd0, Z, Z, 68'd63, 68'd62, 1'b1, 6'd31},
    '{2'd2, 3'd0, 68'd23, 68'd22, 68'd21, 68'd20, 1'b1, 6'd5},
    '{2'd2, 3'd0, 68'd11, 68'd3,  68'd9,  68'd8,  1'b1, 6'd2},
    '{2'd2, 3'd0, 68'd11, 68'd10, 68'd9,  68'd9,  1'b0, 6'd0},
    '{2'd2, 3'd0, 68'd63, 68'd62, 68'd61, 68'd60, 1'b1, 6'd15},
    '{2'd3, 3'd0, Z, Z, Z, 68'd7,    1'b1, 6'd7}
  };

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [1:0]     cfg_shape = '0;
  logic           wr_en = 1'b0;
  logic [5:0]     wr_row = '0;
  logic [W-1:0]   wr_data = '0;
  logic [W-1:0]   wr_mask = '0;
  logic           gm_wr_en = 1'b0;
  logic [2:0]     gm_wr_sel = '0;
  logic [W-1:0]   gm_wr_data = '0;
  logic           rd_en = 1'b0;
  logic [5:0]     rd_row = '0;
  logic [W-1:0]   rd_data;
  logic [W-1:0]   rd_mask;
  logic           srch_en = 1'b0;
  logic [4*W-1:0] srch_key = '0;
  logic [2:0]     srch_gm_sel = '0;
  logic           res_vld;
  logic           res_hit;
  logic [5:0]     res_idx;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  tcam_search u0 (
    .clk(clk), .rst_n(rst_n), .cfg_shape(cfg_shape),
    .wr_en(wr_en), .wr_row(wr_row), .wr_data(wr_data), .wr_mask(wr_mask),
    .gm_wr_en(gm_wr_en), .gm_wr_sel(gm_wr_sel), .gm_wr_data(gm_wr_data),
    .rd_en(rd_en), .rd_row(rd_row), .rd_data(rd_data), .rd_mask(rd_mask),
    .srch_en(srch_en), .srch_key(srch_key), .srch_gm_sel(srch_gm_sel),
    .res_vld(res_vld), .res_hit(res_hit), .res_idx(res_idx)
  );

  task automatic chk(input string req, input logic [71:0] act, input logic [71:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic write_row(input int r, input logic [W-1:0] d, input logic [W-1:0] m);
    @(negedge clk);
    wr_en = 1'b1; wr_row = 6'(r); wr_data = d; wr_mask = m;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic write_gm(input int g, input logic [W-1:0] d);
    @(negedge clk);
    gm_wr_en = 1'b1; gm_wr_sel = 3'(g); gm_wr_data = d;
    @(negedge clk);
    gm_wr_en = 1'b0;
  endtask

  // Result registered at the posedge after issue; checked at the next negedge, hold one cycle later.
  task automatic search(input string req, input logic [1:0] mode, input logic [2:0] gsel,
                        input logic [4*W-1:0] key, input logic eh, input logic [5:0] ei);
    @(negedge clk);
    cfg_shape = mode; srch_gm_sel = gsel; srch_key = key; srch_en = 1'b1;
    @(negedge clk);
    srch_en = 1'b0;
    chk({req, " R2 vld"}, 72'(res_vld), 72'(1));
    chk({req, " result"}, {65'(res_hit), 1'b0, res_idx}, {65'(eh), 1'b0, ei});
    srch_key = '1;
    @(negedge clk);
    chk({req, " R2 pulse end"}, 72'(res_vld), 72'(0));
    chk({req, " R2 hold"}, {65'(res_hit), 1'b0, res_idx}, {65'(eh), 1'b0, ei});
  endtask

  task automatic read_row(input string req, input int r, input logic [W-1:0] ed, input logic [W-1:0] em);
    @(negedge clk);
    rd_en = 1'b1; rd_row = 6'(r);
    @(negedge clk);
    rd_en = 1'b0;
    chk({req, " rd_data"}, 72'(rd_data), 72'(ed));
    chk({req, " rd_mask"}, 72'(rd_mask), 72'(em));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1: reset state of outputs
    chk("R1 res_vld", 72'(res_vld), 72'(0));
    chk("R1 res_hit/idx", {65'(res_hit), 1'b0, res_idx}, 72'(0));
    chk("R1 rd_data", 72'(rd_data), 72'(0));
    @(negedge clk);
    rst_n = 1'b1;
    // R1: array content after reset (data 0, mask all ones)
    search("R1 zero key", 2'd0, 3'd0, '0, 1'b1, 6'd0);
    search("R1 nonzero key", 2'd0, 3'd0, (4*W)'(1), 1'b0, 6'd0);
    read_row("R1 read", 5, '0, '1);

    // Load table contents: row r holds r, row 10 ignores its low nibble (R3)
    for (int r = 0; r < 64; r++) write_row(r, W'(r), '1);
    write_row(10, W'(5), ~W'(15));
    write_gm(3, W'(8'hF0));
    write_gm(7, {1'b1, 67'd0});

    for (int i = 0; i < NV; i++) begin
      // R3 R4 R5 R6 R7 covered by the vector table
      search($sformatf("R7 vec%0d", i), VECS[i].mode, VECS[i].gsel,
             {VECS[i].k3, VECS[i].k2, VECS[i].k1, VECS[i].k0}, VECS[i].hit, VECS[i].idx);
    end

    // R8: read back the row with a stored don't-care field
    read_row("R8 read", 10, W'(5), ~W'(15));

    // R8: a write in the same cycle as a search is invisible to it
    @(negedge clk);
    cfg_shape = 2'd0; srch_gm_sel = 3'd0; srch_key = (4*W)'(8'h99); srch_en = 1'b1;
    wr_en = 1'b1; wr_row = 6'd40; wr_data = W'(8'h99); wr_mask = '1;
    @(negedge clk);
    srch_en = 1'b0; wr_en = 1'b0;
    chk("R8 same-cycle miss", {65'(res_hit), 1'b0, res_idx}, 72'(0));
    search("R8 later hit", 2'd0, 3'd0, (4*W)'(8'h99), 1'b1, 6'd40);

    // R9: highest entry of each shape
    search("R9 x4 top", 2'd2, 3'd0, {W'(63), W'(62), W'(61), W'(60)}, 1'b1, 6'd15);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule